// File: doc/BRIEF.md
# Carrier Divisor Sweep with Averaged Amplitude Capture

This block walks the clock divisor of a low-frequency carrier generator downward through a fixed range and records an amplitude figure for each setting. The result is a resonance profile of the antenna circuit. For each divisor the sequencer presents the value on its divisor output. It then waits a settle interval so the tuned circuit can reach steady state. After that it collects a burst of 32 readings from an external converter through a request/acknowledge handshake.

The 32 readings are summed and reduced to a rounded mean. The mean is rescaled by a fixed-point factor to a byte, and the byte is stored in an on-block result memory at the address equal to the divisor. Before the first step, every location of that memory is zeroed. A one-cycle start pulse begins a sweep, and a one-cycle done pulse marks its end. The host then reads the profile through a combinational read port.

Top module: `lf_divsweep`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `adc_req_o` are low and `div_o` holds 255.
- R2: While busy, the divisor takes the values 255, 254, ... down to 20, each exactly one below the previous one, and never goes below 20.
- R3: After each new divisor is presented, no conversion is requested for at least the settle interval. The interval is CLK_HZ/1000 × SETTLE_MS clock cycles (100 cycles with the bench parameters).
- R4: Exactly 32 conversions complete for every divisor. Once `adc_req_o` is raised, it stays high until a cycle in which `adc_ack_i` is high, and the reading on `adc_data_i` is taken in that cycle.
- R5: The mean for a step is (sum of the 32 readings + 15) >> 5, where each reading is a 10-bit value from 0 to 1023.
- R6: The stored byte is the low 8 bits of (137500 × mean) >> 18. No intermediate value overflows, so a mean of 1023 stores 24 and a mean of 489 stores 0.
- R7: The byte for a step is written at the memory address equal to that step's divisor, and it can be read back through `rd_addr_i`/`rd_data_o` with zero latency.
- R8: All 256 memory locations are written with zero before the first step, so addresses 0 to 19 read zero after a sweep.
- R9: `done_o` is high for exactly one cycle, directly after the write for divisor 20, and `busy_o` is low in that cycle.
- R10: A start pulse that arrives while `busy_o` is high has no effect: the sweep continues from its current divisor and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| div_o | output | 8 | Carrier divisor currently applied |
| adc_req_o | output | 1 | Conversion request, held until acknowledged |
| adc_ack_i | input | 1 | Conversion complete; data valid this cycle |
| adc_data_i | input | 10 | Converter reading |
| busy_o | output | 1 | Sweep in progress (clearing or stepping) |
| done_o | output | 1 | One-cycle pulse at sweep end |
| rd_addr_i | input | 8 | Result memory read address |
| rd_data_o | output | 8 | Result byte at `rd_addr_i` |

## Verification
The bench targets the arithmetic edges. The rounding threshold is probed with sums of 32×488+16 and 32×488+17: a design that dropped the +15 rounding term, or that added the full half-step, moves one of these to the wrong side and stores 255 where 0 is due, or the reverse. The byte wrap at a mean of 489 and the full-scale mean of 1023 expose a multiplier or accumulator that is too narrow, which would store a saturated or corrupted value instead of 0 or 24. The first and last divisors (255 and 20) catch off-by-one loop bounds, which show up as a missing step, an extra step at 19, or a done pulse at the wrong time. Unwritten low addresses reading non-zero show a skipped clear, and a second start pulse in mid-sweep would show up as a restart at 255 if it were not ignored.

// File: rtl/lfsw_pkg.sv
package lfsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_SAMPLE,
        ST_GAP,
        ST_WRITE,
        ST_DONE
    } sweep_state_e;

endpackage

// File: rtl/lfsw_settle.sv
module lfsw_settle #(
    parameter int unsigned CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt = CW'(CYCLES);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired_o = (q.cnt == '0);

    // R3: the dwell counter runs down one per cycle until it is reloaded
    a_r3_settle_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && q.cnt != '0) |=> (q.cnt == $past(q.cnt) - CW'(1)));

    a_r3_settle_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o);

endmodule

// File: rtl/lfsw_avg.sv
module lfsw_avg #(
    parameter int unsigned ADC_W    = 10,
    parameter int unsigned NSAMP    = 32,
    parameter int unsigned SCALE_K  = 137500,
    parameter int unsigned SCALE_SH = 18,
    parameter int unsigned OUT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic [ADC_W-1:0] sample_i,
    output logic             last_o,
    output logic [OUT_W-1:0] result_o
);
    localparam int unsigned SH     = $clog2(NSAMP);
    localparam int unsigned CNT_W  = $clog2(NSAMP + 1);
    localparam int unsigned ACC_W  = ADC_W + SH + 1;
    localparam int unsigned SC_W   = $clog2(SCALE_K + 1);
    localparam int unsigned PROD_W = ADC_W + SC_W;
    localparam int unsigned ROUND  = NSAMP / 2 - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } avg_t;

    avg_t q, d;
    logic [ACC_W-1:0]  rounded;
    logic [ADC_W-1:0]  mean;
    logic [PROD_W-1:0] prod;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.acc = '0;
            d.cnt = '0;
        end else if (add_i) begin
            d.acc = q.acc + ACC_W'(sample_i);
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rounded  = q.acc + ACC_W'(ROUND);
        mean     = ADC_W'(rounded >> SH);
        prod     = PROD_W'(mean) * PROD_W'(SCALE_K);
        result_o = OUT_W'(prod >> SCALE_SH);
    end

    assign last_o = (q.cnt == CNT_W'(NSAMP - 1));

    // R4: never more than the burst length accumulated
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(NSAMP));

    // R5: the sum cannot exceed the count times full scale
    a_r5_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.acc) <= 32'(q.cnt) * ((32'd1 << ADC_W) - 32'd1));

endmodule

// File: rtl/lfsw_resmem.sv
module lfsw_resmem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/lf_divsweep.sv
module lf_divsweep
    import lfsw_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SETTLE_MS = 20,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIV_HI    = 255,
    parameter int unsigned DIV_LO    = 20,
    parameter int unsigned ADC_W     = 10,
    parameter int unsigned NSAMP     = 32,
    parameter int unsigned SCALE_K   = 137500,
    parameter int unsigned SCALE_SH  = 18,
    parameter int unsigned OUT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [DIV_W-1:0] div_o,
    output logic             adc_req_o,
    input  logic             adc_ack_i,
    input  logic [ADC_W-1:0] adc_data_i,
    output logic             busy_o,
    output logic             done_o,
    input  logic [DIV_W-1:0] rd_addr_i,
    output logic [OUT_W-1:0] rd_data_o
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

    typedef struct packed {
        sweep_state_e     state;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] clr;
    } seq_t;

    seq_t q, d;

    logic             tmr_load, tmr_expired;
    logic             avg_clear, avg_add, avg_last;
    logic [OUT_W-1:0] avg_result;
    logic             mem_we;
    logic [DIV_W-1:0] mem_waddr;
    logic [OUT_W-1:0] mem_wdata;

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        avg_clear = 1'b0;
        avg_add   = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = q.div;
        mem_wdata = avg_result;
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.div   = DIV_W'(DIV_HI);
                    d.clr   = '0;
                    d.state = ST_CLEAR;
                end else begin
                    d.state = ST_IDLE;
                end
            end
            ST_CLEAR: begin
                mem_we    = 1'b1;
                mem_waddr = q.clr;
                mem_wdata = '0;
                d.clr     = q.clr + DIV_W'(1);
                if (q.clr == '1) begin
                    tmr_load  = 1'b1;
                    avg_clear = 1'b1;
                    d.state   = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) d.state = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (adc_ack_i) begin
                    avg_add = 1'b1;
                    d.state = avg_last ? ST_WRITE : ST_GAP;
                end
            end
            ST_GAP: begin
                d.state = ST_SAMPLE;
            end
            ST_WRITE: begin
                mem_we = 1'b1;
                if (q.div == DIV_W'(DIV_LO)) begin
                    d.state = ST_DONE;
                end else begin
                    d.div     = q.div - DIV_W'(1);
                    tmr_load  = 1'b1;
                    avg_clear = 1'b1;
                    d.state   = ST_SETTLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.div   <= DIV_W'(DIV_HI);
            q.clr   <= '0;
        end else begin
            q <= d;
        end
    end

    assign div_o     = q.div;
    assign adc_req_o = (q.state == ST_SAMPLE);
    assign busy_o    = (q.state != ST_IDLE) && (q.state != ST_DONE);
    assign done_o    = (q.state == ST_DONE);

    lfsw_settle #(
        .CYCLES (SETTLE_CYC)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    lfsw_avg #(
        .ADC_W    (ADC_W),
        .NSAMP    (NSAMP),
        .SCALE_K  (SCALE_K),
        .SCALE_SH (SCALE_SH),
        .OUT_W    (OUT_W)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (avg_clear),
        .add_i    (avg_add),
        .sample_i (adc_data_i),
        .last_o   (avg_last),
        .result_o (avg_result)
    );

    lfsw_resmem #(
        .AW (DIV_W),
        .DW (OUT_W)
    ) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    // R2: divisor stays within the sweep range while busy
    a_r2_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (div_o >= DIV_W'(DIV_LO)));

    // R2: while a sweep runs, any divisor change is a single decrement
    a_r2_div_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o && div_o != $past(div_o)) |-> (div_o == $past(div_o) - DIV_W'(1)));

    // R4: request held until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req_o && !adc_ack_i) |=> adc_req_o);

    // R9: done is a single-cycle pulse and never overlaps busy
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R10: a start during a sweep never raises the divisor again
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (div_o <= $past(div_o)));

endmodule

// File: tb/lf_divsweep_bench.sv
module lf_divsweep_bench;

    localparam int unsigned SETTLE_CYC = 100;   // 5000 Hz * 20 ms / 1000
    localparam int unsigned NVEC = 11;

    typedef struct packed {
        logic [7:0] div;
        logic [9:0] base;
        logic [4:0] extra;
        logic [7:0] expb;
    } vec_t;

    // divisor, reading level, extra added to first reading, expected byte
    localparam vec_t TBL [NVEC] = '{
        '{8'd255, 10'd1023, 5'd0,  8'd24 },
        '{8'd20,  10'd2,    5'd0,  8'd1  },
        '{8'd21,  10'd489,  5'd0,  8'd0  },
        '{8'd22,  10'd488,  5'd0,  8'd255},
        '{8'd100, 10'd488,  5'd16, 8'd255},
        '{8'd101, 10'd488,  5'd17, 8'd0  },
        '{8'd150, 10'd476,  5'd0,  8'd249},
        '{8'd151, 10'd477,  5'd0,  8'd250},
        '{8'd200, 10'd0,    5'd0,  8'd0  },
        '{8'd60,  10'd100,  5'd0,  8'd52 },
        '{8'd90,  10'd512,  5'd0,  8'd12 }
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] div_o;
    logic       adc_req_o;
    logic       adc_ack_i = 1'b0;
    logic [9:0] adc_data_i = '0;
    logic       busy_o, done_o;
    logic [7:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    int pattern = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lf_divsweep #(
        .CLK_HZ    (5000),
        .SETTLE_MS (20)
    ) u_lf_divsweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .div_o      (div_o),
        .adc_req_o  (adc_req_o),
        .adc_ack_i  (adc_ack_i),
        .adc_data_i (adc_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int reading(input int dv, input int k, input int pat);
        if (pat == 0) begin
            for (int i = 0; i < NVEC; i++)
                if (int'(TBL[i].div) == dv)
                    return int'(TBL[i].base) + ((k == 0) ? int'(TBL[i].extra) : 0);
            return dv * 3;
        end
        return 1023 - dv * 2;
    endfunction

    function automatic int ref_byte(input int dv, input int pat);
        longint sum = 0;
        longint mean;
        for (int k = 0; k < 32; k++) sum += reading(dv, k, pat);
        mean = (sum + 15) / 32;
        return int'(((mean * 137500) / 262144) % 256);
    endfunction

    // converter model: acknowledge one cycle after a request, with a reading
    int   k_idx = 0;
    logic [7:0] seen_div = 8'd255;
    always @(posedge clk) begin
        int kk;
        kk = (div_o != seen_div) ? 0 : k_idx;
        seen_div <= div_o;
        if (!rst_n) begin
            adc_ack_i <= 1'b0;
            k_idx     <= 0;
        end else if (adc_req_o && !adc_ack_i) begin
            adc_ack_i  <= 1'b1;
            adc_data_i <= 10'(reading(int'(div_o), kk, pattern));
            k_idx      <= kk + 1;
        end else begin
            adc_ack_i <= 1'b0;
            k_idx     <= kk;
        end
    end

    // protocol monitor
    logic [7:0] m_div = 8'd255;
    int  m_hs = 0, m_gap = 0, m_done = 0;
    bit  m_wait = 0, m_busy_p = 0, m_req_p = 0, m_ack_p = 0, m_done_p = 0;
    bit  m_hold_err = 0, m_floor_err = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o && !m_busy_p) begin
                chk("R2 sweep begins at 255", div_o, 255);
                m_hs = 0;
            end
            if (busy_o && m_busy_p && div_o != m_div) begin
                chk("R2 divisor decrements by one", div_o, 32'(m_div) - 1);
                chk("R4 32 conversions per divisor", m_hs, 32);
                m_hs = 0; m_gap = 0; m_wait = 1;
            end else if (m_wait) begin
                if (adc_req_o) begin
                    chk("R3 settle interval before first request",
                        (m_gap >= SETTLE_CYC && m_gap <= SETTLE_CYC + 2), 1);
                    m_wait = 0;
                end else m_gap++;
            end
            if (busy_o && div_o < 8'd20 && !m_floor_err) begin
                m_floor_err = 1;
                chk("R2 divisor floor", div_o, 20);
            end
            if (m_req_p && !m_ack_p && !adc_req_o && !m_hold_err) begin
                m_hold_err = 1;
                chk("R4 request dropped before ack", 0, 1);
            end
            if (adc_req_o && adc_ack_i) m_hs++;
            if (done_o) begin
                m_done++;
                chk("R9 done follows divisor 20", div_o, 20);
                chk("R9 last step had 32 conversions", m_hs, 32);
                chk("R9 busy low during done", busy_o, 0);
            end
            if (m_done_p) chk("R9 done lasts one cycle", done_o, 0);
        end
        m_div = div_o; m_busy_p = busy_o; m_req_p = adc_req_o;
        m_ack_p = adc_ack_i; m_done_p = done_o;
    end

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        rd_addr_i = 8'(a);
        #1;
        v = rd_data_o;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] d_before;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 req after reset", adc_req_o, 0);
        chk("R1 divisor after reset", div_o, 255);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 stays idle without start", busy_o, 0);

        // sweep 1 with table-driven readings
        pattern = 0;
        pulse_start();
        repeat (6000) @(negedge clk);
        d_before = div_o;
        pulse_start();                       // R10: must be ignored
        repeat (3) @(negedge clk);
        chk("R10 start while busy does not restart", (div_o <= d_before && div_o != 8'd255), 1);
        chk("R10 still busy", busy_o, 1);
        wait_done();
        repeat (5) @(negedge clk);
        chk("R10 single done pulse", m_done, 1);

        // R5/R6/R7 table of hand-computed corner values
        for (int i = 0; i < NVEC; i++) begin
            rd(int'(TBL[i].div), v);
            chk($sformatf("R6 R7 table entry divisor %0d", TBL[i].div), v, TBL[i].expb);
        end
        // R5/R6/R7 every divisor against the reference formula
        for (int dv = 20; dv <= 255; dv++) begin
            rd(dv, v);
            chk($sformatf("R5 R7 divisor %0d", dv), v, ref_byte(dv, 0));
        end
        // R8 locations never stepped to read zero
        for (int a = 0; a < 20; a++) begin
            rd(a, v);
            chk($sformatf("R8 cleared address %0d", a), v, 0);
        end

        // sweep 2 with a second pattern
        pattern = 1;
        pulse_start();
        wait_done();
        repeat (2) @(negedge clk);
        chk("R9 second sweep done count", m_done, 2);
        for (int dv = 20; dv <= 255; dv += 47) begin
            rd(dv, v);
            chk($sformatf("R6 second sweep divisor %0d", dv), v, ref_byte(dv, 1));
        end
        rd(5, v);
        chk("R8 low address still zero", v, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule